// File: doc/BRIEF.md
# PSRAM Chip-Enable Pulse Limiter

This block sits between a synchronous PSRAM burst requester and the memory's active-low chip-enable pin. A requester hands it one burst at a time: a target bank, a start address and a word count. The block then drives chip-enable low and acknowledges one word per clock, presenting the current word address each time.

Some PSRAM devices only refresh while chip-enable is high, so the time chip-enable may stay low is limited. A single programmable limit value is shared by all banks. Each bank has its own enable bit that decides whether the limit applies to it. For an enabled bank, a down-timer is loaded with the limit every time chip-enable falls, and it counts one step per clock while chip-enable stays low.

When the timer expires, the block finishes the word it is on and raises chip-enable for a fixed two-clock refresh gap. It then lowers chip-enable again and pulses a restart strobe with the address of the next untransferred word. The requester sees one transfer whose total acknowledged words equal the request; only the chip-enable waveform is broken up.

Top module: `psram_ce_limiter`

## Requirements
- R1: After reset, chip-enable is high, no word is acknowledged, the block is idle, and the limit value is zero, so a burst to an enabled bank runs unsplit until a limit is written.
- R2: For a burst to an enabled bank with nonzero limit N, each chip-enable low pulse lasts exactly N clocks (one word per clock) unless fewer words remain, in which case it lasts for the remaining words.
- R3: Between two pulses of a split burst, chip-enable stays high for exactly 2 clocks and no word is acknowledged.
- R4: On every falling edge of chip-enable, the restart strobe is high for exactly that first low clock. The word address shown then is the first word not yet transferred, and it increments by one on each later acknowledged word of the pulse.
- R5: The total number of acknowledged words of a burst equals the requested word count, whether or not it is split.
- R6: A burst to a bank whose enable bit is clear holds chip-enable low for the whole transfer, whatever the limit value is.
- R7: A limit value of zero disables splitting for every bank.
- R8: The single limit value applies to every enabled bank. Bank-enable bit i belongs to bank number i.
- R9: When a burst finishes, chip-enable goes high and the block is idle in the next clock. The next burst starts with a fresh load of the limit.
- R10: A request presented while a burst is in progress is ignored and does not disturb the running burst.
- R11: A request with a word count of zero is ignored: chip-enable stays high and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| limitWrEn | input | 1 | Write strobe for the shared limit value |
| limitWrData | input | CNT_W | New limit value (0 = never split) |
| bankEnWrEn | input | 1 | Write strobe for the per-bank enable bits |
| bankEnWrData | input | NUM_BANKS | Enable bit i applies to bank i |
| reqValid | input | 1 | Burst request, accepted when idle |
| reqBank | input | BANK_W | Target bank of the request |
| reqLen | input | LEN_W | Number of words to transfer |
| reqAddr | input | ADDR_W | Address of the first word |
| ceN | output | 1 | Active-low chip-enable to the memory |
| startStb | output | 1 | High in the first clock of each chip-enable low pulse |
| wordAddr | output | ADDR_W | Address of the word being transferred |
| wordAck | output | 1 | One word transferred in this clock |
| busy | output | 1 | A burst is in progress |

## Verification
Bursts are run with lengths shorter than, equal to, and longer than the limit, which separates an off-by-one in the timer load or expiry from a correct split. The same limit is tried on enabled and disabled banks and with value zero, which tells the per-bank gating apart from the global disable. A limit of one forces a split after every word and exposes gap-length and restart-address faults. Back-to-back bursts and requests held active during a burst show whether the timer is freshly reloaded and whether mid-burst requests leak into the transfer. Random bursts over all banks, lengths and limits are compared clock by clock against a bench model of the expected chip-enable waveform.

// File: rtl/psram_lim_pkg.sv
package psram_lim_pkg;

  localparam int GAP_CLKS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } lim_state_e;

  typedef struct packed {
    logic accept;   // capture a new burst
    logic reload;   // load the low-time timer from the limit
    logic step;     // one word transferred this clock
  } lim_strobes_t;

endpackage

// File: rtl/psram_lim_dp.sv
module psram_lim_dp
  import psram_lim_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 10,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 24,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 limitWrEn,
  input  logic [CNT_W-1:0]     limitWrData,
  input  logic                 bankEnWrEn,
  input  logic [NUM_BANKS-1:0] bankEnWrData,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  lim_strobes_t         stb,
  output logic                 lastWord,
  output logic                 splitDue,
  output logic [ADDR_W-1:0]    curAddr
);

  logic [CNT_W-1:0]     limitReg;
  logic [NUM_BANKS-1:0] bankEnReg;
  logic [LEN_W-1:0]     remCnt;
  logic [CNT_W-1:0]     lowTimer;
  logic                 splitOn;

  // shared configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitReg  <= '0;
      bankEnReg <= '0;
    end else begin
      if (limitWrEn)  limitReg  <= limitWrData;
      if (bankEnWrEn) bankEnReg <= bankEnWrData;
    end
  end

  // burst position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      remCnt  <= '0;
      splitOn <= 1'b0;
    end else if (stb.accept) begin
      curAddr <= reqAddr;
      remCnt  <= reqLen;
      splitOn <= bankEnReg[reqBank];
    end else if (stb.step) begin
      curAddr <= curAddr + ADDR_W'(1);
      remCnt  <= remCnt - LEN_W'(1);
    end
  end

  // low-time timer: loaded at each chip-enable fall, counts while low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowTimer <= '0;
    end else if (stb.reload) begin
      lowTimer <= limitReg;
    end else if (stb.step && lowTimer != '0) begin
      lowTimer <= lowTimer - CNT_W'(1);
    end
  end

  assign lastWord = (remCnt == LEN_W'(1));
  // a zero limit never reaches one, so splitting is off
  assign splitDue = splitOn && (lowTimer == CNT_W'(1));

endmodule

// File: rtl/psram_lim_ctrl.sv
module psram_lim_ctrl
  import psram_lim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqGo,
  input  logic         lastWord,
  input  logic         splitDue,
  output lim_strobes_t stb,
  output logic         ceN,
  output logic         startStb,
  output logic         wordAck,
  output logic         busy
);

  localparam int GAP_W = $clog2(GAP_CLKS) + 1;

  lim_state_e state, stateNxt;
  logic [GAP_W-1:0] gapCnt, gapCntNxt;
  logic firstStb, firstStbNxt;

  always_comb begin
    stateNxt    = state;
    gapCntNxt   = gapCnt;
    firstStbNxt = 1'b0;
    stb         = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqGo) begin
          stb.accept  = 1'b1;
          stb.reload  = 1'b1;
          firstStbNxt = 1'b1;
          stateNxt    = ST_RUN;
        end
      end
      ST_RUN: begin
        stb.step = 1'b1;
        if (lastWord) begin
          stateNxt = ST_IDLE;
        end else if (splitDue) begin
          stateNxt  = ST_GAP;
          gapCntNxt = GAP_W'(GAP_CLKS - 1);
        end
      end
      ST_GAP: begin
        if (gapCnt == '0) begin
          stb.reload  = 1'b1;
          firstStbNxt = 1'b1;
          stateNxt    = ST_RUN;
        end else begin
          gapCntNxt = gapCnt - GAP_W'(1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapCnt   <= '0;
      firstStb <= 1'b0;
    end else begin
      state    <= stateNxt;
      gapCnt   <= gapCntNxt;
      firstStb <= firstStbNxt;
    end
  end

  assign ceN      = (state != ST_RUN);
  assign wordAck  = (state == ST_RUN);
  assign startStb = firstStb;
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/psram_ce_limiter.sv
module psram_ce_limiter
  import psram_lim_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 10,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 24,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 limitWrEn,
  input  logic [CNT_W-1:0]     limitWrData,
  input  logic                 bankEnWrEn,
  input  logic [NUM_BANKS-1:0] bankEnWrData,
  input  logic                 reqValid,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 ceN,
  output logic                 startStb,
  output logic [ADDR_W-1:0]    wordAddr,
  output logic                 wordAck,
  output logic                 busy
);

  lim_strobes_t stb;
  logic lastWord, splitDue, reqGo;

  assign reqGo = reqValid && (reqLen != '0);

  psram_lim_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqGo    (reqGo),
    .lastWord (lastWord),
    .splitDue (splitDue),
    .stb      (stb),
    .ceN      (ceN),
    .startStb (startStb),
    .wordAck  (wordAck),
    .busy     (busy)
  );

  psram_lim_dp #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W),
    .LEN_W     (LEN_W),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .limitWrEn    (limitWrEn),
    .limitWrData  (limitWrData),
    .bankEnWrEn   (bankEnWrEn),
    .bankEnWrData (bankEnWrData),
    .reqBank      (reqBank),
    .reqLen       (reqLen),
    .reqAddr      (reqAddr),
    .stb          (stb),
    .lastWord     (lastWord),
    .splitDue     (splitDue),
    .curAddr      (wordAddr)
  );

endmodule

// File: rtl/psram_ce_limiter_chk.sv
module psram_ce_limiter_chk #(
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              startStb,
  input logic              wordAck,
  input logic              busy,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [CNT_W-1:0]  limitVal,
  input logic              splitOn
);

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= '0;
    else if (ceN) lowRun <= '0;
    else if (lowRun != 16'hFFFF) lowRun <= lowRun + 16'd1;
  end

  // R2
  ce_low_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && splitOn && limitVal != '0) |-> (lowRun < 16'(limitVal)));

  // R3
  gap_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ceN) && busy) |=> (ceN && !wordAck));

  // R4
  restart_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceN) |-> startStb);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordAck && !startStb) |-> (wordAddr == $past(wordAddr) + ADDR_W'(1)));

  // R9
  idle_ce_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ceN && !wordAck));

endmodule

bind psram_ce_limiter psram_ce_limiter_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .startStb (startStb),
  .wordAck  (wordAck),
  .busy     (busy),
  .wordAddr (wordAddr),
  .limitVal (u_dp.limitReg),
  .splitOn  (u_dp.splitOn)
);

// File: tb/psram_ce_limiter_tb.sv
module psram_ce_limiter_tb;

  localparam int NB     = 4;
  localparam int CNT_W  = 10;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 24;
  localparam int BW     = $clog2(NB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic limitWrEn = 1'b0;
  logic [CNT_W-1:0] limitWrData = '0;
  logic bankEnWrEn = 1'b0;
  logic [NB-1:0] bankEnWrData = '0;
  logic reqValid = 1'b0;
  logic [BW-1:0] reqBank = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic ceN, startStb, wordAck, busy;
  logic [ADDR_W-1:0] wordAddr;

  always #2 clk = ~clk;

  psram_ce_limiter #(.NUM_BANKS(NB), .CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .limitWrEn(limitWrEn), .limitWrData(limitWrData),
    .bankEnWrEn(bankEnWrEn), .bankEnWrData(bankEnWrData),
    .reqValid(reqValid), .reqBank(reqBank), .reqLen(reqLen), .reqAddr(reqAddr),
    .ceN(ceN), .startStb(startStb), .wordAddr(wordAddr), .wordAck(wordAck), .busy(busy)
  );

  int vecs = 0;
  int errs = 0;
  int mdlLimit = 0;
  logic [NB-1:0] mdlEn = '0;
  int segs;

  task automatic chk(input string req, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expSegs(input int bank, input int len);
    if (mdlEn[bank] && mdlLimit != 0) return (len + mdlLimit - 1) / mdlLimit;
    return 1;
  endfunction

  task automatic writeLimit(input int v);
    @(negedge clk); limitWrEn = 1'b1; limitWrData = CNT_W'(v);
    @(negedge clk); limitWrEn = 1'b0;
    mdlLimit = v;
  endtask

  task automatic writeEn(input logic [NB-1:0] v);
    @(negedge clk); bankEnWrEn = 1'b1; bankEnWrData = v;
    @(negedge clk); bankEnWrEn = 1'b0;
    mdlEn = v;
  endtask

  // drives one burst and checks every clock against the model
  task automatic runBurst(input int bank, input int len, input logic [ADDR_W-1:0] addr,
                          input bit noisy, output int nSegs);
    int rem, seg, gap, acks;
    bit split;
    logic [ADDR_W-1:0] a;
    split = mdlEn[bank] && mdlLimit != 0;
    @(negedge clk);
    reqValid = 1'b1; reqBank = BW'(bank); reqLen = LEN_W'(len); reqAddr = addr;
    @(posedge clk);
    rem = len; a = addr; seg = 0; gap = 0; acks = 0; nSegs = 0;
    while (rem > 0) begin
      @(negedge clk);
      if (noisy) begin
        reqAddr = ADDR_W'($urandom); reqBank = BW'($urandom); reqLen = LEN_W'($urandom % 50 + 1);
      end else reqValid = 1'b0;
      if (gap > 0) begin
        chk("R3 gap ceN", ceN, 1);
        chk("R3 gap wordAck", wordAck, 0);
        gap--;
      end else begin
        chk("R2 ceN low", ceN, 0);
        chk("R5 wordAck", wordAck, 1);
        chk("R4 startStb", startStb, seg == 0);
        chk("R4 wordAddr", wordAddr, a);
        if (seg == 0) nSegs++;
        a = a + ADDR_W'(1); rem--; seg++; acks++;
        if (rem > 0 && split && seg == mdlLimit) begin gap = 2; seg = 0; end
      end
      if (rem == 0) reqValid = 1'b0;
    end
    chk("R5 total acks", acks, len);
    @(negedge clk);
    chk("R9 ceN released", ceN, 1);
    chk("R9 idle", busy, 0);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset ceN", ceN, 1);
    chk("R1 reset wordAck", wordAck, 0);
    chk("R1 reset busy", busy, 0);

    // R1: limit resets to zero -> no split even when enabled
    writeEn(4'b1111);
    runBurst(0, 20, 24'h000100, 0, segs);
    chk("R1 reset limit unsplit", segs, 1);

    // R2: limit 4, 10 words -> 4+4+2
    writeLimit(4);
    runBurst(0, 10, 24'h001000, 0, segs);
    chk("R2 segments", segs, 3);

    // R2: limit 1 splits after every word
    writeLimit(1);
    runBurst(3, 4, 24'hFFFFFE, 0, segs);
    chk("R2 limit one", segs, 4);

    // R7: zero limit disables splitting
    writeLimit(0);
    runBurst(0, 10, 24'h002000, 0, segs);
    chk("R7 zero limit", segs, 1);

    // R6 / R8: bank gating, shared limit
    writeLimit(3);
    writeEn(4'b0101);
    runBurst(1, 9, 24'h003000, 0, segs);
    chk("R6 disabled bank", segs, 1);
    runBurst(2, 9, 24'h004000, 0, segs);
    chk("R8 shared limit bank2", segs, 3);
    runBurst(0, 7, 24'h004100, 0, segs);
    chk("R8 shared limit bank0", segs, 3);

    // R9: length equal to limit, then fresh reload on next burst
    runBurst(0, 3, 24'h005000, 0, segs);
    chk("R9 len equals limit", segs, 1);
    runBurst(0, 7, 24'h005100, 0, segs);
    chk("R9 fresh reload", segs, 3);

    // R10: requests held during a burst are ignored
    runBurst(2, 11, 24'h006000, 1, segs);
    chk("R10 noisy burst", segs, 4);
    @(negedge clk);
    chk("R10 no stray start", busy, 0);

    // R11: zero-length request ignored
    @(negedge clk);
    reqValid = 1'b1; reqLen = '0; reqAddr = 24'h007000;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 zero len ceN", ceN, 1);
    chk("R11 zero len busy", busy, 0);
    @(negedge clk);
    chk("R11 zero len later", busy, 0);

    // constrained random
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 40; i++) begin
      int b, l;
      if (i % 5 == 0) writeLimit($urandom % 10);
      if (i % 7 == 0) writeEn(NB'($urandom));
      b = $urandom % NB;
      l = $urandom % 40 + 1;
      runBurst(b, l, ADDR_W'($urandom), (i % 3) == 0, segs);
      chk("R8 random segments", segs, expSegs(b, l));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule